// File: doc/BRIEF.md
# Interleaved Four-Context AES-128 Encryption Ring

This block encrypts 128-bit blocks under 128-bit keys for up to four independent task contexts, numbered 0 to 3. The work of one cipher round is divided into four register stages. The stage boundaries sit on each side of the byte substitution and on each side of the column mixing. The four contexts take turns in those stages, so the same round logic carries four encryptions at once. Every block passes through the ring ten times.

A block enters through one input port. The port carries the block, its key and a 2-bit context number. The slot for context c opens only on the cycle in which that context's stage position comes round to the entry point. Each in-flight block carries its own key, and the key for the next round is derived on the fly from the current one. A finished block waits in a per-context result register. One output port presents the waiting results with their context numbers, and a result stays on that port until it is taken.

Top module: `aes_ctx_ring`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, out_valid is 0 and every context is idle. That first cycle has rotation phase 0.
- R2: The rotation phase is 0 on the first cycle after reset and goes up by one (mod 4) every cycle. in_ready is 1 exactly when in_tag equals the phase and context in_tag is idle. A block is taken on a cycle with in_valid and in_ready both high.
- R3: The result is the AES-128 encryption of in_block under in_key. Byte i of a value sits at bits [127-8i:120-8i], and bytes fill the state column by column. Key 000102..0f with block 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: A block taken at a clock edge has its result pending from exactly 40 clock edges later. out_valid is 1 whenever any result is pending.
- R5: Suppose four blocks for contexts 0, 1, 2 and 3 are taken on four consecutive cycles, starting at phase 0, and out_ready stays high. Then the result for context 3 appears on the output 43 edges after context 0 was taken.
- R6: Once out_valid is 1 with out_ready 0, the next cycle shows the same out_tag and out_data, with out_valid still 1.
- R7: If no result is being held under R6, the output shows the lowest-numbered context with a pending result. A result leaves when out_valid and out_ready are both high.
- R8: A context stays busy from the cycle its block is taken until its result leaves the output. While busy it refuses new blocks (in_ready 0), and its pending result is never overwritten.
- R9: Rounds 1 to 9 apply substitution, row shift, column mixing and round-key addition, in that order. Round 10 skips the column mixing. A block advances one round every four cycles, and it returns to the ring entry only on its own context's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A block is offered |
| in_ready | output | 1 | The offered context can take a block on this cycle |
| in_tag | input | 2 | Context number of the offered block |
| in_block | input | 128 | Plaintext block |
| in_key | input | 128 | Cipher key for this block |
| out_valid | output | 1 | A finished result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| out_tag | output | 2 | Context number of the presented result |
| out_data | output | 128 | Ciphertext |

## Verification
The assertions assume three things about the inputs: in_tag is always a known value, a block counts as taken only when in_ready is high, and out_ready may drop at any time. Under those assumptions, the ring-alignment property and the no-overwrite property follow from the ready rule alone. The stimulus presents each queued block unchanged until the bench's own model predicts acceptance, and it drives out_ready from a random pattern during the backpressure phase. A directed phase also keeps offering a block to a context whose result is still waiting. This exercises the refusal path without breaking the handshake.

// File: rtl/aes_ring_pkg.sv
package aes_ring_pkg;
  localparam int NCTX   = 4;
  localparam int TAG_W  = $clog2(NCTX);
  localparam int STG    = 4;
  localparam int NROUND = 10;
  localparam int RND_W  = $clog2(NROUND + 1);
  localparam int BLK_W  = 128;

  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [RND_W-1:0] rnd;
  } ctl_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p  = '0;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] x2, x3, x6, x12, x15, x30, x60, x120, x240, inv;
    x2   = gmul(x, x);
    x3   = gmul(x2, x);
    x6   = gmul(x3, x3);
    x12  = gmul(x6, x6);
    x15  = gmul(x12, x3);
    x30  = gmul(x15, x15);
    x60  = gmul(x30, x30);
    x120 = gmul(x60, x60);
    x240 = gmul(x120, x120);
    inv  = gmul(gmul(x240, x12), x2);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic blk_t shift_rows(input blk_t s);
    blk_t o;
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[BLK_W-1-8*(r+4*c) -: 8] = s[BLK_W-1-8*(r+4*((c+r)%4)) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [7:0] rcon(input logic [RND_W-1:0] r);
    case (r)
      RND_W'(1):  return 8'h01;
      RND_W'(2):  return 8'h02;
      RND_W'(3):  return 8'h04;
      RND_W'(4):  return 8'h08;
      RND_W'(5):  return 8'h10;
      RND_W'(6):  return 8'h20;
      RND_W'(7):  return 8'h40;
      RND_W'(8):  return 8'h80;
      RND_W'(9):  return 8'h1b;
      RND_W'(10): return 8'h36;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] din,
  output logic [8*NB-1:0] dout
);
  import aes_ring_pkg::*;

  generate
    for (genvar i = 0; i < NB; i++) begin : g_byte
      assign dout[8*i +: 8] = sbox(din[8*i +: 8]);
    end
  endgenerate
endmodule

// File: rtl/aes_mix_stage.sv
module aes_mix_stage
  import aes_ring_pkg::*;
(
  input  blk_t din,
  input  logic bypass,
  output blk_t dout
);
  localparam int NCOL = BLK_W / 32;
  blk_t mixed;

  generate
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      assign mixed[32*c +: 32] = mix_col(din[32*c +: 32]);
    end
  endgenerate

  assign dout = bypass ? din : mixed;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_ring_pkg::*;
(
  input  blk_t             key_in,
  input  logic [RND_W-1:0] rnd,
  output blk_t             key_out
);
  logic [31:0] w0, w1, w2, w3, rot, sub, t;
  logic [31:0] n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = key_in;
  assign rot = {w3[23:0], w3[31:24]};

  aes_sbox_bank #(.NB(4)) u_word_sbox (
    .din  (rot),
    .dout (sub)
  );

  assign t  = sub ^ {rcon(rnd), 24'h000000};
  assign n0 = w0 ^ t;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign key_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_result_arb.sv
module aes_result_arb
  import aes_ring_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCTX-1:0]             res_vld,
  input  logic [NCTX-1:0][BLK_W-1:0]  res_dat,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [TAG_W-1:0]            out_tag,
  output logic [BLK_W-1:0]            out_data,
  output logic [NCTX-1:0]             out_take
);
  logic             lock_q, lock_d;
  logic [TAG_W-1:0] sel_q, sel_d, pick;

  always_comb begin
    pick = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (res_vld[i]) pick = TAG_W'(i);
    end
    sel_d     = lock_q ? sel_q : pick;
    out_valid = |res_vld;
    out_tag   = sel_d;
    out_data  = res_dat[sel_d];
    out_take  = '0;
    if (out_valid && out_ready) out_take[sel_d] = 1'b1;
    lock_d    = out_valid && !out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      lock_q <= lock_d;
      sel_q  <= sel_d;
    end
  end

  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)))
    else $error("held result changed");

  p_take_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_take) && ((out_take & ~res_vld) == '0))
    else $error("take of a non-pending context");
endmodule

// File: rtl/aes_ctx_ring.sv
module aes_ctx_ring
  import aes_ring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [BLK_W-1:0]   in_block,
  input  logic [BLK_W-1:0]   in_key,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [TAG_W-1:0]   out_tag,
  output logic [BLK_W-1:0]   out_data
);
  localparam int LAST = STG - 1;

  // control state (reset) and datapath state (no reset)
  logic [TAG_W-1:0]           ph_q, ph_d;
  ctl_t                       ctl_q [STG];
  ctl_t                       ctl_d [STG];
  blk_t                       st_q  [STG];
  blk_t                       st_d  [STG];
  blk_t                       key_q [STG];
  blk_t                       key_d [STG];
  logic [STG-1:0]             st_en;
  logic [NCTX-1:0]            run_q, run_d, res_vld_q, res_vld_d, busy, take;
  logic [NCTX-1:0][BLK_W-1:0] res_dat_q;

  blk_t sub_out, sr_out, mix_out, nk, ark;
  logic cont, fin, load;

  // stage 0 -> 1: byte substitution between two registers
  aes_sbox_bank #(.NB(BLK_W/8)) u_state_sbox (
    .din  (st_q[0]),
    .dout (sub_out)
  );

  assign sr_out = shift_rows(st_q[1]);

  // stage 2 -> 3: column mixing, skipped in the last round
  aes_mix_stage u_mix (
    .din    (st_q[2]),
    .bypass (ctl_q[2].rnd == RND_W'(NROUND)),
    .dout   (mix_out)
  );

  // stage 3 -> 0: next round key and key addition
  aes_key_step u_key (
    .key_in  (key_q[LAST]),
    .rnd     (ctl_q[LAST].rnd),
    .key_out (nk)
  );

  assign ark  = st_q[LAST] ^ nk;
  assign cont = ctl_q[LAST].vld && (ctl_q[LAST].rnd != RND_W'(NROUND));
  assign fin  = ctl_q[LAST].vld && (ctl_q[LAST].rnd == RND_W'(NROUND));
  assign busy = run_q | res_vld_q;
  assign in_ready = (in_tag == ph_q) && !busy[ph_q];
  assign load = in_valid && in_ready;

  aes_result_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_vld   (res_vld_q),
    .res_dat   (res_dat_q),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_data  (out_data),
    .out_take  (take)
  );

  always_comb begin
    ph_d = ph_q + TAG_W'(1);

    ctl_d[0] = '0;
    if (cont) begin
      ctl_d[0].vld = 1'b1;
      ctl_d[0].tag = ctl_q[LAST].tag;
      ctl_d[0].rnd = ctl_q[LAST].rnd + RND_W'(1);
    end else if (load) begin
      ctl_d[0].vld = 1'b1;
      ctl_d[0].tag = in_tag;
      ctl_d[0].rnd = RND_W'(1);
    end
    st_d[0]  = cont ? ark : (in_block ^ in_key);
    key_d[0] = cont ? nk : in_key;
    st_en[0] = cont || load;

    for (int s = 1; s < STG; s++) begin
      ctl_d[s] = ctl_q[s-1];
      key_d[s] = key_q[s-1];
      st_en[s] = ctl_q[s-1].vld;
    end
    st_d[1] = sub_out;
    st_d[2] = sr_out;
    st_d[3] = mix_out;

    run_d     = run_q;
    res_vld_d = res_vld_q & ~take;
    if (load) run_d[in_tag] = 1'b1;
    if (fin) begin
      run_d[ctl_q[LAST].tag]     = 1'b0;
      res_vld_d[ctl_q[LAST].tag] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= '0;
      run_q     <= '0;
      res_vld_q <= '0;
      for (int s = 0; s < STG; s++) ctl_q[s] <= '0;
    end else begin
      ph_q      <= ph_d;
      run_q     <= run_d;
      res_vld_q <= res_vld_d;
      for (int s = 0; s < STG; s++) ctl_q[s] <= ctl_d[s];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < STG; s++) begin
      if (st_en[s]) begin
        st_q[s]  <= st_d[s];
        key_q[s] <= key_d[s];
      end
    end
    if (fin) res_dat_q[ctl_q[LAST].tag] <= ark;
  end

  p_ring_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[LAST].vld |-> (ctl_q[LAST].tag == ph_q))
    else $error("block returned off its phase");

  p_round_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[0].vld |-> (ctl_q[0].rnd >= RND_W'(1) && ctl_q[0].rnd <= RND_W'(NROUND)))
    else $error("round counter out of range");

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (run_q[ctl_q[LAST].tag] && !res_vld_q[ctl_q[LAST].tag]))
    else $error("result written over a pending one");

  p_load_marks_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy[$past(in_tag)])
    else $error("taken context not busy");
endmodule

// File: tb/aes_ctx_ring_tb.sv
module aes_ctx_ring_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [1:0]   in_tag, out_tag;
  logic [127:0] in_block, in_key, out_data;

  aes_ctx_ring dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_block(in_block), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_data(out_data)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  logic [7:0]   sb [256];
  int           mst [4];
  int           mcnt [4];
  logic [127:0] mres [4];
  logic [127:0] taken [4];
  bit           mlock;
  int           msel, mph, stepn, acc0, seen3;
  bit           last_acc, bp;
  logic [1:0]   ptag;
  logic [127:0] pdata;
  logic [127:0] q_blk [$];
  logic [127:0] q_key [$];
  int           q_tag [$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_aes(input logic [127:0] pt, input logic [127:0] k);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] w [16];
    logic [7:0] tmp [4];
    logic [7:0] a0, a1, a2, a3, rc;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ w[i];
    end
    rc = 8'h01;
    for (int rd = 1; rd <= 10; rd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r+4*c] = t[r+4*((c+r)%4)];
      if (rd < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = gm(a0, 2) ^ gm(a1, 3) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ gm(a1, 2) ^ gm(a2, 3) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ gm(a2, 2) ^ gm(a3, 3);
          s[4*c+3] = gm(a0, 3) ^ a1 ^ a2 ^ gm(a3, 2);
        end
      end
      tmp[0] = sb[w[13]] ^ rc; tmp[1] = sb[w[14]];
      tmp[2] = sb[w[15]];      tmp[3] = sb[w[12]];
      for (int j = 0; j < 4; j++) w[j] = w[j] ^ tmp[j];
      for (int i = 4; i < 16; i++) w[i] = w[i] ^ w[i-4];
      rc = gm(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  function automatic bit all_idle();
    for (int c = 0; c < 4; c++) if (mst[c] != 0) return 0;
    return 1;
  endfunction

  // one clock: compare at mid-cycle, advance model to the next edge
  task automatic step();
    bit er, ov, tk, ac;
    int low, sel;
    #1;
    er  = (int'(in_tag) == mph) && (mst[mph] == 0);
    low = -1;
    for (int c = 3; c >= 0; c--) if (mst[c] == 2) low = c;
    ov  = (low >= 0);
    sel = mlock ? msel : low;
    chk(in_ready === er, "R2 in_ready", 128'(in_ready), 128'(er));
    chk(out_valid === ov, "R4 out_valid", 128'(out_valid), 128'(ov));
    if (ov) begin
      chk(out_tag === 2'(sel), "R7 out_tag", 128'(out_tag), 128'(sel));
      chk(out_data === mres[sel], "R3 R9 out_data", out_data, mres[sel]);
    end
    if (mlock) chk(out_tag === ptag && out_data === pdata, "R6 hold", out_data, pdata);
    tk = ov && out_ready;
    ac = in_valid && er;
    if (tk) taken[sel] = out_data;
    if (ac && in_tag == 2'd0 && acc0 < 0) acc0 = stepn;
    if (ov && out_tag == 2'd3 && seen3 < 0) seen3 = stepn;
    for (int c = 0; c < 4; c++) begin
      if (mst[c] == 1) begin
        mcnt[c]--;
        if (mcnt[c] == 0) mst[c] = 2;
      end
    end
    if (tk) mst[sel] = 0;
    mlock = ov && !out_ready;
    msel  = sel;
    if (ac) begin
      mst[in_tag]  = 1;
      mcnt[in_tag] = 40;
      mres[in_tag] = ref_aes(in_block, in_key);
    end
    mph = (mph + 1) % 4;
    ptag = out_tag; pdata = out_data;
    last_acc = ac;
    stepn++;
    @(negedge clk);
  endtask

  task automatic push(input int tg, input logic [127:0] b, input logic [127:0] k);
    q_tag.push_back(tg); q_blk.push_back(b); q_key.push_back(k);
  endtask

  task automatic run_queue();
    while (q_tag.size() > 0 || !all_idle()) begin
      if (q_tag.size() > 0) begin
        in_valid = 1'b1; in_tag = 2'(q_tag[0]);
        in_block = q_blk[0]; in_key = q_key[0];
      end else begin
        in_valid = 1'b0;
      end
      out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
      step();
      if (last_acc) begin
        void'(q_tag.pop_front()); void'(q_blk.pop_front()); void'(q_key.pop_front());
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] inv;
    logic [7:0] cst;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      cst = 8'h63;
      for (int i = 0; i < 8; i++)
        sb[x][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ cst[i];
    end
    for (int c = 0; c < 4; c++) begin mst[c] = 0; mcnt[c] = 0; mres[c] = '0; end
    mlock = 0; msel = 0; mph = 0; stepn = 0; acc0 = -1; seen3 = -1; bp = 0;
    in_valid = 0; in_tag = 0; in_block = '0; in_key = '0; out_ready = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1 out_valid in reset", 128'(out_valid), 128'd0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid === 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
    chk(in_ready === 1'b1, "R1 context 0 open at phase 0", 128'(in_ready), 128'd1);

    // R3: known-answer vector
    chk(ref_aes(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f)
        === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 bench reference",
        ref_aes(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    push(0, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
    run_queue();
    chk(taken[0] === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 known-answer vector",
        taken[0], 128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R5: four contexts issued back to back from phase 0
    while (mph != 0) step();
    acc0 = -1; seen3 = -1;
    for (int c = 0; c < 4; c++) push(c, {4{$urandom}}, {4{$urandom}});
    run_queue();
    chk((seen3 - acc0 - 1) == 43, "R5 four contexts in 43 cycles",
        128'(seen3 - acc0 - 1), 128'd43);

    // R8: busy context refuses a new block and keeps its result
    push(2, {4{$urandom}}, {4{$urandom}});
    bp = 0;
    while (q_tag.size() > 0) begin
      in_valid = 1'b1; in_tag = 2'(q_tag[0]); in_block = q_blk[0]; in_key = q_key[0];
      out_ready = 1'b0;
      step();
      if (last_acc) begin
        void'(q_tag.pop_front()); void'(q_blk.pop_front()); void'(q_key.pop_front());
      end
    end
    in_valid = 1'b0;
    while (mst[2] != 2) step();
    for (int n = 0; n < 8; n++) begin
      in_valid = 1'b1; in_tag = 2'd2; in_block = {4{$urandom}}; in_key = {4{$urandom}};
      #1;
      chk(in_ready === 1'b0, "R8 busy context refuses", 128'(in_ready), 128'd0);
      chk(out_data === mres[2], "R8 pending result kept", out_data, mres[2]);
      step();
    end
    in_valid = 1'b0;
    run_queue();

    // R6 R7: random contexts and data under output backpressure
    bp = 1;
    for (int j = 0; j < 150; j++) push($urandom % 4, {4{$urandom}}, {4{$urandom}});
    run_queue();
    bp = 0;
    repeat (4) step();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule